// File: doc/BRIEF.md
# Exception Entry Vector and Cause Controller

This block works out what happens to the processor state on the cycle an exception is taken. A single-cycle request pulse brings an exception class code, the faulting program counter, a delay-slot flag, a refill flag and a coprocessor number. The pulse also samples a copy of the relevant status bits: bootstrap vectors, exception level, vectored interrupts and debug mode. Software supplies an exception base address.

One clock later the block drives a set of registered results. These are the handler address, a return address, and a strobe for each architectural register that has to change. The strobes cover the exception PC, the error PC, the debug PC, the cause code, the branch-delay flag, the coprocessor-number field and the status bits. The surrounding state logic applies those strobes.

Exceptions fall into three entry paths. The general path covers traps, faults and interrupts and goes through the base plus a class-dependent offset. The error path covers non-maskable interrupt and soft reset and uses a fixed vector. The debug path also uses a fixed vector. The request pin has no ready signal: a pulse is accepted on every cycle it is high, and there is no back-pressure.

Top module: `exc_vector_ctrl`

## Requirements
- R1: A general exception goes to base + 0x180. The base is 0xBFC00200 when `st_bev`=1. Otherwise the base is `ebase` with bits [9:0] forced to zero.
- R2: An interrupt (code 0) with `st_iv`=1 uses offset 0x200 instead of 0x180.
- R3: A TLB load or store miss (code 2 or 3) with `tlb_refill`=1 and `st_exl`=0 uses offset 0x000. With `st_exl`=1 the same request uses 0x180.
- R4: A cache error (code 16) uses offset 0x100 when `st_bev`=1 and offset 0x20000100 when `st_bev`=0. It writes cause code 30.
- R5: For general codes 0 to 13, `cause_we` pulses and `cause_val` equals the input code. These codes are: 0 interrupt, 1 TLB modify, 2 TLB load, 3 TLB store, 4 address error load, 5 address error store, 6 instruction bus error, 7 data bus error, 8 syscall, 9 break, 10 reserved instruction, 11 coprocessor unusable, 12 overflow and 13 trap.
- R6: For a general exception with `st_exl`=0, `epc_we`, `bd_we`, `set_exl` and `force_kernel` all pulse. `ret_pc` is `cur_pc`-4 with `bd_val`=1 when `in_dslot`=1, and `cur_pc` with `bd_val`=0 otherwise. With `st_exl`=1, none of these four strobes pulse.
- R7: Codes 17 (non-maskable interrupt) and 18 (soft reset) pulse `errpc_we`, `set_erl`, `set_bev` and `force_kernel`. They use the same delay-slot return correction and go to 0xBFC00000. They do not write the cause.
- R8: Debug codes 20 to 24 pulse `depc_we`, `enter_dm` and `force_kernel`, use the delay-slot correction and go to 0xBFC00480. Single step (code 19) does the same but with `ret_pc` = `cur_pc` regardless of `in_dslot`.
- R9: An interrupt (code 0) taken while `dbg_mode`=1 follows the debug path and does not write the cause.
- R10: Coprocessor unusable (code 11) also pulses `ce_we` with `ce_val` = `cop_num`. No other code pulses `ce_we`.
- R11: Results appear, with `upd_valid` high for exactly one cycle, in the cycle after the clock edge that samples `take_exc`=1. Without a request every strobe stays low.
- R12: A code outside {0..13, 16..24} pulses `bad_code` and leaves `upd_valid` and every strobe low.
- R13: During and right after reset, `upd_valid`, `bad_code` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_exc | input | 1 | Single-cycle request to take an exception |
| exc_code | input | 5 | Exception class code |
| cur_pc | input | XLEN | Program counter of the faulting instruction |
| in_dslot | input | 1 | Faulting instruction sits in a branch delay slot |
| tlb_refill | input | 1 | TLB miss is a refill (no matching entry) |
| cop_num | input | 2 | Coprocessor number for coprocessor-unusable |
| st_bev | input | 1 | Bootstrap-vector status bit |
| st_exl | input | 1 | Exception-level status bit |
| st_iv | input | 1 | Vectored-interrupt bit |
| dbg_mode | input | 1 | Processor is in debug mode |
| ebase | input | XLEN | Exception base address |
| upd_valid | output | 1 | Results valid this cycle |
| bad_code | output | 1 | Unknown exception code was requested |
| next_pc | output | XLEN | Handler address |
| ret_pc | output | XLEN | Return address for the written PC register |
| epc_we | output | 1 | Write exception PC |
| bd_we | output | 1 | Write branch-delay flag |
| bd_val | output | 1 | Branch-delay flag value |
| cause_we | output | 1 | Write cause code |
| cause_val | output | 5 | Cause code value |
| ce_we | output | 1 | Write coprocessor-number field |
| ce_val | output | 2 | Coprocessor-number value |
| errpc_we | output | 1 | Write error PC |
| depc_we | output | 1 | Write debug PC |
| set_exl | output | 1 | Set exception-level bit |
| set_erl | output | 1 | Set error-level bit |
| set_bev | output | 1 | Set bootstrap-vector bit |
| enter_dm | output | 1 | Enter debug mode |
| force_kernel | output | 1 | Force kernel mode |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 10-bit base alignment, the usual vectors and a 4-byte instruction step. The exception base it drives has low bits set, so the alignment mask is exercised. It also drives a faulting PC whose delay-slot correction borrows across a byte boundary. Together these settings reach every vector offset: the base-dependent general, interrupt, refill and cache-error offsets, and the three fixed entry addresses. The return-address arithmetic is checked on each path.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [4:0] {
    EC_INT      = 5'd0,
    EC_TLB_MOD  = 5'd1,
    EC_TLB_LD   = 5'd2,
    EC_TLB_ST   = 5'd3,
    EC_ADR_LD   = 5'd4,
    EC_ADR_ST   = 5'd5,
    EC_IBUS     = 5'd6,
    EC_DBUS     = 5'd7,
    EC_SYSCALL  = 5'd8,
    EC_BREAK    = 5'd9,
    EC_RSVD     = 5'd10,
    EC_COPU     = 5'd11,
    EC_OVF      = 5'd12,
    EC_TRAP     = 5'd13,
    EC_CACHE    = 5'd16,
    EC_NMI      = 5'd17,
    EC_SRESET   = 5'd18,
    EC_DSTEP    = 5'd19,
    EC_DINT     = 5'd20,
    EC_DIBRK    = 5'd21,
    EC_DBRK     = 5'd22,
    EC_DDST     = 5'd23,
    EC_DDLD     = 5'd24
  } exc_code_e;

  typedef enum logic [1:0] {
    PATH_GEN = 2'd0,
    PATH_ERR = 2'd1,
    PATH_DBG = 2'd2,
    PATH_BAD = 2'd3
  } entry_path_e;

  typedef struct packed {
    entry_path_e path;
    logic [4:0]  cause;
    logic        is_int;
    logic        is_tlb_miss;
    logic        is_cache;
    logic        is_copu;
    logic        no_ret_fix;
  } exc_dec_t;

  localparam logic [4:0]  CAUSE_CACHE   = 5'd30;
  localparam logic [31:0] OFF_GENERAL   = 32'h0000_0180;
  localparam logic [31:0] OFF_VEC_INT   = 32'h0000_0200;
  localparam logic [31:0] OFF_REFILL    = 32'h0000_0000;
  localparam logic [31:0] OFF_CACHE_BT  = 32'h0000_0100;
  localparam logic [31:0] OFF_CACHE_RUN = 32'h2000_0100;

endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_pkg::*;
(
  input  logic [4:0] code,
  input  logic       dm,
  output exc_dec_t   dec
);
  always_comb begin
    dec             = '0;
    dec.path        = PATH_GEN;
    dec.cause       = code;
    unique case (code)
      EC_INT: begin
        if (dm) begin
          dec.path = PATH_DBG;
        end else begin
          dec.is_int = 1'b1;
        end
      end
      EC_TLB_LD, EC_TLB_ST: dec.is_tlb_miss = 1'b1;
      EC_COPU:              dec.is_copu = 1'b1;
      EC_TLB_MOD, EC_ADR_LD, EC_ADR_ST, EC_IBUS, EC_DBUS,
      EC_SYSCALL, EC_BREAK, EC_RSVD, EC_OVF, EC_TRAP: ;
      EC_CACHE: begin
        dec.is_cache = 1'b1;
        dec.cause    = CAUSE_CACHE;
      end
      EC_NMI, EC_SRESET: dec.path = PATH_ERR;
      EC_DSTEP: begin
        dec.path       = PATH_DBG;
        dec.no_ret_fix = 1'b1;
      end
      EC_DINT, EC_DIBRK, EC_DBRK, EC_DDST, EC_DDLD: dec.path = PATH_DBG;
      default: dec.path = PATH_BAD;
    endcase
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          EB_LSB    = 10,
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [31:0] ERR_VEC   = 32'hBFC0_0000,
  parameter logic [31:0] DBG_VEC   = 32'hBFC0_0480
) (
  input  exc_dec_t        dec,
  input  logic            bev,
  input  logic            exl,
  input  logic            iv,
  input  logic            refill,
  input  logic [XLEN-1:0] ebase,
  output logic [XLEN-1:0] vec
);
  localparam logic [XLEN-1:0] EB_MASK = {XLEN{1'b1}} << EB_LSB;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    base = bev ? XLEN'(BOOT_BASE) : (ebase & EB_MASK);
    if (dec.is_cache) begin
      offset = bev ? XLEN'(OFF_CACHE_BT) : XLEN'(OFF_CACHE_RUN);
    end else if (dec.is_tlb_miss && refill && !exl) begin
      offset = XLEN'(OFF_REFILL);
    end else if (dec.is_int && iv) begin
      offset = XLEN'(OFF_VEC_INT);
    end else begin
      offset = XLEN'(OFF_GENERAL);
    end
    unique case (dec.path)
      PATH_ERR: vec = XLEN'(ERR_VEC);
      PATH_DBG: vec = XLEN'(DBG_VEC);
      default:  vec = base + offset;
    endcase
  end
endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic            dslot,
  input  logic            no_fix,
  output logic [XLEN-1:0] ret,
  output logic            bd
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_comb begin
    bd  = dslot && !no_fix;
    ret = bd ? (pc - STEP) : pc;
  end
endmodule

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl
  import exc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          EB_LSB     = 10,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] BOOT_BASE  = 32'hBFC0_0200,
  parameter logic [31:0] ERR_VEC    = 32'hBFC0_0000,
  parameter logic [31:0] DBG_VEC    = 32'hBFC0_0480
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_exc,
  input  logic [4:0]      exc_code,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            in_dslot,
  input  logic            tlb_refill,
  input  logic [1:0]      cop_num,
  input  logic            st_bev,
  input  logic            st_exl,
  input  logic            st_iv,
  input  logic            dbg_mode,
  input  logic [XLEN-1:0] ebase,
  output logic            upd_valid,
  output logic            bad_code,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] ret_pc,
  output logic            epc_we,
  output logic            bd_we,
  output logic            bd_val,
  output logic            cause_we,
  output logic [4:0]      cause_val,
  output logic            ce_we,
  output logic [1:0]      ce_val,
  output logic            errpc_we,
  output logic            depc_we,
  output logic            set_exl,
  output logic            set_erl,
  output logic            set_bev,
  output logic            enter_dm,
  output logic            force_kernel
);
  exc_dec_t        dec;
  logic [XLEN-1:0] vec;
  logic [XLEN-1:0] ret;
  logic            bd;
  logic            is_gen, is_err, is_dbg, is_bad, gen_first;

  exc_decode u_dec (
    .code (exc_code),
    .dm   (dbg_mode),
    .dec  (dec)
  );

  exc_vector_sel #(
    .XLEN(XLEN), .EB_LSB(EB_LSB), .BOOT_BASE(BOOT_BASE),
    .ERR_VEC(ERR_VEC), .DBG_VEC(DBG_VEC)
  ) u_vec (
    .dec    (dec),
    .bev    (st_bev),
    .exl    (st_exl),
    .iv     (st_iv),
    .refill (tlb_refill),
    .ebase  (ebase),
    .vec    (vec)
  );

  exc_ret_addr #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_ret (
    .pc     (cur_pc),
    .dslot  (in_dslot),
    .no_fix (dec.no_ret_fix),
    .ret    (ret),
    .bd     (bd)
  );

  always_comb begin
    is_gen    = take_exc && (dec.path == PATH_GEN);
    is_err    = take_exc && (dec.path == PATH_ERR);
    is_dbg    = take_exc && (dec.path == PATH_DBG);
    is_bad    = take_exc && (dec.path == PATH_BAD);
    gen_first = is_gen && !st_exl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid    <= 1'b0;
      bad_code     <= 1'b0;
      epc_we       <= 1'b0;
      bd_we        <= 1'b0;
      cause_we     <= 1'b0;
      ce_we        <= 1'b0;
      errpc_we     <= 1'b0;
      depc_we      <= 1'b0;
      set_exl      <= 1'b0;
      set_erl      <= 1'b0;
      set_bev      <= 1'b0;
      enter_dm     <= 1'b0;
      force_kernel <= 1'b0;
    end else begin
      upd_valid    <= take_exc && !is_bad;
      bad_code     <= is_bad;
      epc_we       <= gen_first;
      bd_we        <= gen_first;
      cause_we     <= is_gen;
      ce_we        <= is_gen && dec.is_copu;
      errpc_we     <= is_err;
      depc_we      <= is_dbg;
      set_exl      <= gen_first;
      set_erl      <= is_err;
      set_bev      <= is_err;
      enter_dm     <= is_dbg;
      force_kernel <= gen_first || is_err || is_dbg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc   <= '0;
      ret_pc    <= '0;
      bd_val    <= 1'b0;
      cause_val <= '0;
      ce_val    <= '0;
    end else if (take_exc && !is_bad) begin
      next_pc   <= vec;
      ret_pc    <= ret;
      bd_val    <= bd;
      cause_val <= dec.cause;
      ce_val    <= cop_num;
    end
  end
endmodule

// File: rtl/exc_vector_ctrl_chk.sv
module exc_vector_ctrl_chk #(
  parameter int          XLEN    = 32,
  parameter logic [31:0] ERR_VEC = 32'hBFC0_0000,
  parameter logic [31:0] DBG_VEC = 32'hBFC0_0480
) (
  input logic            clk,
  input logic            rst_n,
  input logic            take_exc,
  input logic            upd_valid,
  input logic            bad_code,
  input logic [XLEN-1:0] next_pc,
  input logic            epc_we,
  input logic            bd_we,
  input logic            cause_we,
  input logic [4:0]      cause_val,
  input logic            ce_we,
  input logic            errpc_we,
  input logic            depc_we,
  input logic            set_exl,
  input logic            set_erl,
  input logic            set_bev,
  input logic            enter_dm,
  input logic            force_kernel
);
  // R11
  strobe_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (epc_we || cause_we || errpc_we || depc_we || ce_we) |-> upd_valid);
  // R11
  valid_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid || bad_code) |-> $past(take_exc));
  // R12
  bad_is_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |-> !upd_valid && !epc_we && !cause_we && !errpc_we && !depc_we && !force_kernel);
  // R6
  epc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we |-> set_exl && bd_we && force_kernel && cause_we);
  // R7
  err_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errpc_we |-> set_erl && set_bev && force_kernel && next_pc == XLEN'(ERR_VEC));
  // R8
  dbg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depc_we |-> enter_dm && force_kernel && next_pc == XLEN'(DBG_VEC));
  // R9
  one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cause_we, errpc_we, depc_we}));
  // R10
  ce_general_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_we |-> cause_we && cause_val == 5'd11);
endmodule

bind exc_vector_ctrl exc_vector_ctrl_chk #(
  .XLEN(XLEN), .ERR_VEC(ERR_VEC), .DBG_VEC(DBG_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .take_exc(take_exc), .upd_valid(upd_valid),
  .bad_code(bad_code), .next_pc(next_pc), .epc_we(epc_we), .bd_we(bd_we),
  .cause_we(cause_we), .cause_val(cause_val), .ce_we(ce_we),
  .errpc_we(errpc_we), .depc_we(depc_we), .set_exl(set_exl),
  .set_erl(set_erl), .set_bev(set_bev), .enter_dm(enter_dm),
  .force_kernel(force_kernel)
);

// File: tb/exc_vector_ctrl_bench.sv
module exc_vector_ctrl_bench;
  localparam logic [31:0] PC0 = 32'h0040_0100;
  localparam logic [31:0] EB0 = 32'h8000_1234;

  typedef struct packed {
    logic [4:0]  code;
    logic        ds, rf, bev, exl, iv, dm;
    logic [31:0] exp_pc;
    logic [31:0] exp_ret;
    logic [1:0]  exp_path;   // 0 general, 1 error, 2 debug, 3 bad
    logic [4:0]  exp_cause;
    logic        exp_epc;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{5'd8,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 32'h0040_0100, 2'd0, 5'd8,  1'b1}, // R1 R5 R6
    '{5'd8,  1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 32'hBFC0_0380, 32'h0040_00FC, 2'd0, 5'd8,  1'b1}, // R1 R6
    '{5'd0,  1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 32'h8000_1200, 32'h0040_0100, 2'd0, 5'd0,  1'b1}, // R2
    '{5'd0,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 32'h0040_0100, 2'd0, 5'd0,  1'b1}, // R2
    '{5'd2,  1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 32'h8000_1000, 32'h0040_0100, 2'd0, 5'd2,  1'b1}, // R3
    '{5'd3,  1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 32'h8000_1180, 32'h0,         2'd0, 5'd3,  1'b0}, // R3 R6
    '{5'd3,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 32'hBFC0_0200, 32'h0040_0100, 2'd0, 5'd3,  1'b1}, // R3
    '{5'd16, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 32'hBFC0_0300, 32'h0040_0100, 2'd0, 5'd30, 1'b1}, // R4
    '{5'd16, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'hA000_1100, 32'h0040_0100, 2'd0, 5'd30, 1'b1}, // R4
    '{5'd17, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'hBFC0_0000, 32'h0040_00FC, 2'd1, 5'd0,  1'b0}, // R7
    '{5'd18, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'hBFC0_0000, 32'h0040_0100, 2'd1, 5'd0,  1'b0}, // R7
    '{5'd22, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'hBFC0_0480, 32'h0040_00FC, 2'd2, 5'd0,  1'b0}, // R8
    '{5'd19, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'hBFC0_0480, 32'h0040_0100, 2'd2, 5'd0,  1'b0}, // R8
    '{5'd0,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 32'hBFC0_0480, 32'h0040_0100, 2'd2, 5'd0,  1'b0}, // R9
    '{5'd11, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 32'h0040_0100, 2'd0, 5'd11, 1'b1}, // R5 R10
    '{5'd14, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,         32'h0,         2'd3, 5'd0,  1'b0}, // R12
    '{5'd4,  1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 32'h8000_1180, 32'h0,         2'd0, 5'd4,  1'b0}, // R5 R6
    '{5'd13, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h8000_1180, 32'h0040_0100, 2'd0, 5'd13, 1'b1}  // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_exc = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] cur_pc = PC0;
  logic        in_dslot = 1'b0, tlb_refill = 1'b0;
  logic [1:0]  cop_num = '0;
  logic        st_bev = 1'b0, st_exl = 1'b0, st_iv = 1'b0, dbg_mode = 1'b0;
  logic [31:0] ebase = EB0;
  logic        upd_valid, bad_code, epc_we, bd_we, bd_val, cause_we, ce_we;
  logic        errpc_we, depc_we, set_exl, set_erl, set_bev, enter_dm, force_kernel;
  logic [31:0] next_pc, ret_pc;
  logic [4:0]  cause_val;
  logic [1:0]  ce_val;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_vector_ctrl u_exc_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .take_exc(take_exc), .exc_code(exc_code),
    .cur_pc(cur_pc), .in_dslot(in_dslot), .tlb_refill(tlb_refill),
    .cop_num(cop_num), .st_bev(st_bev), .st_exl(st_exl), .st_iv(st_iv),
    .dbg_mode(dbg_mode), .ebase(ebase), .upd_valid(upd_valid),
    .bad_code(bad_code), .next_pc(next_pc), .ret_pc(ret_pc),
    .epc_we(epc_we), .bd_we(bd_we), .bd_val(bd_val), .cause_we(cause_we),
    .cause_val(cause_val), .ce_we(ce_we), .ce_val(ce_val),
    .errpc_we(errpc_we), .depc_we(depc_we), .set_exl(set_exl),
    .set_erl(set_erl), .set_bev(set_bev), .enter_dm(enter_dm),
    .force_kernel(force_kernel)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int i);
    case (i)
      0, 1:         return "R1";
      2, 3:         return "R2";
      4, 5, 6:      return "R3";
      7, 8:         return "R4";
      9, 10:        return "R7";
      11, 12:       return "R8";
      13:           return "R9";
      14:           return "R10";
      15:           return "R12";
      16:           return "R6";
      default:      return "R5";
    endcase
  endfunction

  function automatic logic [2:0] obs_path();
    if (bad_code)      return 3'd3;
    else if (errpc_we) return 3'd1;
    else if (depc_we)  return 3'd2;
    else if (cause_we) return 3'd0;
    else               return 3'd7;
  endfunction

  task automatic fire(input vec_t v);
    @(negedge clk);
    exc_code = v.code; in_dslot = v.ds; tlb_refill = v.rf;
    st_bev = v.bev; st_exl = v.exl; st_iv = v.iv; dbg_mode = v.dm;
    take_exc = 1'b1;
    @(negedge clk);
    take_exc = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13", "valid in reset", {31'b0, upd_valid}, 32'd0);
    chk("R13", "strobes in reset",
        {19'b0, bad_code, epc_we, bd_we, cause_we, ce_we, errpc_we, depc_we,
         set_exl, set_erl, set_bev, enter_dm, force_kernel, 2'b0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", "valid after reset", {31'b0, upd_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      fire(VECS[i]);
      chk(req_of(i), "entry path", {29'b0, obs_path()}, {30'b0, VECS[i].exp_path});
      if (VECS[i].exp_path != 2'd3) begin
        chk(req_of(i), "next_pc", next_pc, VECS[i].exp_pc);
        chk("R11", "upd_valid", {31'b0, upd_valid}, 32'd1);
      end
      if (VECS[i].exp_path == 2'd0) begin
        chk(req_of(i), "cause", {27'b0, cause_val}, {27'b0, VECS[i].exp_cause});
        chk(req_of(i), "epc_we", {31'b0, epc_we}, {31'b0, VECS[i].exp_epc});
      end
      if (VECS[i].exp_epc || VECS[i].exp_path == 2'd1 || VECS[i].exp_path == 2'd2)
        chk(req_of(i), "ret_pc", ret_pc, VECS[i].exp_ret);
    end

    // R6 delay-slot flag value and the untouched strobes under EXL
    fire('{5'd9, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0, 2'd0, 5'd9, 1'b1});
    chk("R6", "bd_val in slot", {31'b0, bd_val}, 32'd1);
    chk("R6", "kernel+exl", {30'b0, set_exl, force_kernel}, 32'd3);
    fire('{5'd9, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 32'h0, 32'h0, 2'd0, 5'd9, 1'b0});
    chk("R6", "no bd/exl/kernel under exl", {29'b0, bd_we, set_exl, force_kernel}, 32'd0);

    // R10 coprocessor number carried, and absent for another code
    cop_num = 2'd2;
    fire('{5'd11, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0, 2'd0, 5'd11, 1'b1});
    chk("R10", "ce strobe+value", {29'b0, ce_we, ce_val}, 32'h6);
    fire('{5'd12, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0, 2'd0, 5'd12, 1'b1});
    chk("R10", "ce quiet for overflow", {31'b0, ce_we}, 32'd0);

    // R7 / R8 status strobes
    fire('{5'd18, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0, 2'd1, 5'd0, 1'b0});
    chk("R7", "erl/bev/no cause", {29'b0, set_erl, set_bev, cause_we}, 32'd6);
    fire('{5'd21, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0, 2'd2, 5'd0, 1'b0});
    chk("R8", "enter_dm", {31'b0, enter_dm}, 32'd1);

    // R11 idle cycle: everything drops
    @(negedge clk);
    chk("R11", "idle quiet",
        {20'b0, upd_valid, bad_code, epc_we, cause_we, ce_we, errpc_we,
         depc_we, set_exl, set_erl, set_bev, enter_dm, force_kernel}, 32'd0);

    // R12 unknown code 31
    fire('{5'd31, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0, 2'd3, 5'd0, 1'b0});
    chk("R12", "bad flag, no valid", {30'b0, bad_code, upd_valid}, 32'd2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule